// File: doc/BRIEF.md
# Clock Source Selection Controller

This block manages which clock drives the CPU of a small microcontroller. Three sources are available: an internal free-running oscillator, an external main oscillator, and a PLL that multiplies the main clock. Software reaches the controller through a byte-wide write port with four addresses. It chooses the source and a power-of-two divider, turns the PLL on and sets its multiplier, and arms the detection of a main-oscillator stop. The controller drives the clock-mux select, the divider code and the PLL controls. The analog oscillators, the PLL and the glitch-free mux cells are outside this block.

The controller enforces the safe-use rules in hardware. The PLL cannot be selected until a settling counter has expired after the PLL was enabled. The multiplier can be written once after reset and is fixed from then on. A low-power entry request is refused while the PLL is in use. A stop of the main oscillator can switch the CPU back to the internal oscillator by itself. A refused operation sets a sticky error flag. A failover sets a sticky flag and raises a one-cycle interrupt.

Write map: address 0 selects the source and divider, address 1 controls the PLL, address 2 arms stop detection, and address 3 clears the status flags.

Top module: `clk_src_ctrl`

## Requirements
- R1: After reset, `src_sel` is 00 (internal oscillator) and `div_code` is 4 (divide by 16). `pll_en`, `pll_mult`, `pll_ready`, `irq`, `failover_flag`, `err_flag`, `wait_go` and `stop_go` are all 0.
- R2: `pll_ready` rises exactly SETTLE_CYCLES clock edges after the edge that sets `pll_en`. It drops when `pll_en` is cleared, and the count starts again from zero on every new enable.
- R3: A write to address 0 is rejected as a whole, with the source and divider unchanged and `err_flag` set, in two cases: the source field `wr_data[1:0]` is 10 (PLL) while `pll_ready` is 0, or the field holds the reserved code 11. The PLL is never the source while `pll_ready` is 0.
- R4: A write to address 0 that is not rejected loads `src_sel` from `wr_data[1:0]` and `div_code` from `wr_data[6:4]`. The source codes are 00 internal, 01 main and 10 PLL, and the divide ratio is 2 to the power of `div_code`.
- R5: The first write to address 1 after reset loads `pll_mult` from `wr_data[2:0]`, where 001 means ×2 and 010 means ×4. Every later write leaves `pll_mult` unchanged.
- R6: When `main_stopped` rises while both address-2 bits are set (bit 0 arms detection, bit 1 selects the interrupt response), the next edge forces `src_sel` to 00 and sets `failover_flag`. In that same cycle `irq` pulses high for exactly one cycle. With either bit clear, the rise has no effect.
- R7: Writing address 3 with bit 0 set clears `failover_flag`. Writing address 3 with bit 1 set clears `err_flag`.
- R8: A one-cycle `wait_req` produces a one-cycle `wait_go` on the next edge unless the PLL is the source. In that case the request is refused and `err_flag` is set.
- R9: A one-cycle `stop_req` produces a one-cycle `stop_go` on the next edge only if the PLL is neither the source nor enabled. Otherwise the request is refused and `err_flag` is set.
- R10: A write to address 1 that clears bit 7 (the PLL enable) while the PLL is the source leaves `pll_enable` set and sets `err_flag`. Outside that case, bit 7 loads `pll_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| main_stopped | input | 1 | Main oscillator stop indication |
| wait_req | input | 1 | Wait-mode entry request pulse |
| stop_req | input | 1 | Stop-mode entry request pulse |
| src_sel | output | 2 | CPU clock source: 00 internal, 01 main, 10 PLL |
| div_code | output | 3 | CPU clock divider, ratio 2**div_code |
| pll_en | output | 1 | PLL enable |
| pll_mult | output | 3 | PLL multiplier code |
| pll_ready | output | 1 | PLL settling time elapsed |
| irq | output | 1 | One-cycle failover interrupt |
| failover_flag | output | 1 | Sticky failover status |
| err_flag | output | 1 | Sticky rejected-operation status |
| wait_go | output | 1 | Wait-mode entry granted pulse |
| stop_go | output | 1 | Stop-mode entry granted pulse |

## Verification
The hardest state to reach is one where the PLL is the active source, because only a fully settled PLL can be selected. The bench therefore enables the PLL, counts edges to watch `pll_ready` rise at exactly the settling boundary, and only then selects it. From there it tries to disable the PLL and to enter wait and stop, and each attempt must be refused with no state change. Failover is then triggered from the main source, first with detection only half armed to show that nothing happens, and then fully armed.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

    typedef enum logic [1:0] {
        SRC_INT  = 2'b00,
        SRC_MAIN = 2'b01,
        SRC_PLL  = 2'b10,
        SRC_RSVD = 2'b11
    } src_e;

    localparam logic [1:0] ADDR_SRC  = 2'd0;
    localparam logic [1:0] ADDR_PLL  = 2'd1;
    localparam logic [1:0] ADDR_DET  = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    localparam logic [2:0] DIV_RESET = 3'd4;

    typedef struct packed {
        src_e       src;
        logic [2:0] div;
        logic       pll_en;
        logic [2:0] mult;
        logic       mult_lock;
        logic       det_en;
        logic       irq_mode;
        logic       fo_flag;
        logic       err;
        logic       irq;
        logic       wait_go;
        logic       stop_go;
    } ctrl_state_t;

endpackage

// File: rtl/csc_settle_timer.sv
module csc_settle_timer #(
    parameter int SETTLE_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic ready
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rdy;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!enable) begin
            tmr_d.cnt = '0;
            tmr_d.rdy = 1'b0;
        end else if (!tmr_q.rdy) begin
            if (tmr_q.cnt == LAST) begin
                tmr_d.rdy = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign ready = tmr_q.rdy & enable;
endmodule

// File: rtl/csc_failover_det.sv
module csc_failover_det (
    input  logic clk,
    input  logic rst_n,
    input  logic main_stopped,
    input  logic det_en,
    input  logic irq_mode,
    output logic trigger
);
    logic seen_d, seen_q;

    always_comb begin
        seen_d = main_stopped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= seen_d;
        end
    end

    assign trigger = main_stopped & ~seen_q & det_en & irq_mode;
endmodule

// File: rtl/csc_lp_guard.sv
module csc_lp_guard
    import clk_src_pkg::*;
(
    input  logic wait_req,
    input  logic stop_req,
    input  src_e cur_src,
    input  logic pll_on,
    output logic wait_ok,
    output logic stop_ok,
    output logic refused
);
    logic pll_selected;
    logic wait_bad;
    logic stop_bad;

    always_comb begin
        pll_selected = (cur_src == SRC_PLL);
        wait_bad     = wait_req & pll_selected;
        stop_bad     = stop_req & (pll_selected | pll_on);
        wait_ok      = wait_req & ~wait_bad;
        stop_ok      = stop_req & ~stop_bad;
        refused      = wait_bad | stop_bad;
    end
endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
    import clk_src_pkg::*;
#(
    parameter int SETTLE_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       main_stopped,
    input  logic       wait_req,
    input  logic       stop_req,
    output logic [1:0] src_sel,
    output logic [2:0] div_code,
    output logic       pll_en,
    output logic [2:0] pll_mult,
    output logic       pll_ready,
    output logic       irq,
    output logic       failover_flag,
    output logic       err_flag,
    output logic       wait_go,
    output logic       stop_go
);
    localparam ctrl_state_t RESET_STATE = '{
        src:       SRC_INT,
        div:       DIV_RESET,
        pll_en:    1'b0,
        mult:      3'd0,
        mult_lock: 1'b0,
        det_en:    1'b0,
        irq_mode:  1'b0,
        fo_flag:   1'b0,
        err:       1'b0,
        irq:       1'b0,
        wait_go:   1'b0,
        stop_go:   1'b0
    };

    ctrl_state_t st_d, st_q;

    logic ready_w;
    logic fo_trig_w;
    logic wait_ok_w;
    logic stop_ok_w;
    logic lp_refused_w;
    src_e req_src_w;
    logic unused_wr;

    assign unused_wr = wr_data[3];

    csc_settle_timer #(
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (st_q.pll_en),
        .ready  (ready_w)
    );

    csc_failover_det fodet_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .main_stopped (main_stopped),
        .det_en       (st_q.det_en),
        .irq_mode     (st_q.irq_mode),
        .trigger      (fo_trig_w)
    );

    csc_lp_guard guard_i (
        .wait_req (wait_req),
        .stop_req (stop_req),
        .cur_src  (st_q.src),
        .pll_on   (st_q.pll_en),
        .wait_ok  (wait_ok_w),
        .stop_ok  (stop_ok_w),
        .refused  (lp_refused_w)
    );

    assign req_src_w = src_e'(wr_data[1:0]);

    always_comb begin
        st_d         = st_q;
        st_d.irq     = 1'b0;
        st_d.wait_go = 1'b0;
        st_d.stop_go = 1'b0;

        if (wr_en) begin
            case (wr_addr)
                ADDR_SRC: begin
                    if (req_src_w == SRC_RSVD) begin
                        st_d.err = 1'b1;
                    end else if (req_src_w == SRC_PLL && !ready_w) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.src = req_src_w;
                        st_d.div = wr_data[6:4];
                    end
                end
                ADDR_PLL: begin
                    if (!st_q.mult_lock) begin
                        st_d.mult      = wr_data[2:0];
                        st_d.mult_lock = 1'b1;
                    end
                    if (!wr_data[7] && st_q.src == SRC_PLL) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.pll_en = wr_data[7];
                    end
                end
                ADDR_DET: begin
                    st_d.det_en   = wr_data[0];
                    st_d.irq_mode = wr_data[1];
                end
                default: begin
                    if (wr_data[0]) begin
                        st_d.fo_flag = 1'b0;
                    end
                    if (wr_data[1]) begin
                        st_d.err = 1'b0;
                    end
                end
            endcase
        end

        st_d.wait_go = wait_ok_w;
        st_d.stop_go = stop_ok_w;
        if (lp_refused_w) begin
            st_d.err = 1'b1;
        end

        if (fo_trig_w) begin
            st_d.src     = SRC_INT;
            st_d.irq     = 1'b1;
            st_d.fo_flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_sel       = st_q.src;
    assign div_code      = st_q.div;
    assign pll_en        = st_q.pll_en;
    assign pll_mult      = st_q.mult;
    assign pll_ready     = ready_w;
    assign irq           = st_q.irq;
    assign failover_flag = st_q.fo_flag;
    assign err_flag      = st_q.err;
    assign wait_go       = st_q.wait_go;
    assign stop_go       = st_q.stop_go;
endmodule

// File: rtl/csc_checker.sv
module csc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] src_sel,
    input logic       pll_en,
    input logic [2:0] pll_mult,
    input logic       pll_ready,
    input logic       irq,
    input logic       wait_go,
    input logic       stop_go
);
    AST_PLL_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'b10) |-> pll_ready); // R3

    AST_READY_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_en) |=> !pll_ready); // R2

    AST_MULT_WRITE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_mult != $past(pll_mult)) |-> ($past(pll_mult) == 3'd0)); // R5

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R6

    AST_IRQ_FORCES_INT: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (src_sel == 2'b00)); // R6

    AST_WAIT_NOT_ON_PLL: assert property (@(posedge clk) disable iff (!rst_n)
        wait_go |-> ($past(src_sel) != 2'b10)); // R8

    AST_STOP_PLL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        stop_go |-> (!$past(pll_en) && $past(src_sel) != 2'b10)); // R9
endmodule

bind clk_src_ctrl csc_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_sel   (src_sel),
    .pll_en    (pll_en),
    .pll_mult  (pll_mult),
    .pll_ready (pll_ready),
    .irq       (irq),
    .wait_go   (wait_go),
    .stop_go   (stop_go)
);

// File: tb/clk_src_ctrl_tb_top.sv
module clk_src_ctrl_tb_top;
    localparam int SETTLE = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       main_stopped = 1'b0;
    logic       wait_req = 1'b0;
    logic       stop_req = 1'b0;
    logic [1:0] src_sel;
    logic [2:0] div_code;
    logic       pll_en;
    logic [2:0] pll_mult;
    logic       pll_ready;
    logic       irq;
    logic       failover_flag;
    logic       err_flag;
    logic       wait_go;
    logic       stop_go;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    clk_src_ctrl #(.SETTLE_CYCLES(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .main_stopped(main_stopped), .wait_req(wait_req),
        .stop_req(stop_req), .src_sel(src_sel), .div_code(div_code),
        .pll_en(pll_en), .pll_mult(pll_mult), .pll_ready(pll_ready),
        .irq(irq), .failover_flag(failover_flag), .err_flag(err_flag),
        .wait_go(wait_go), .stop_go(stop_go)
    );

    typedef struct packed {
        logic [1:0] addr;
        logic [7:0] data;
        logic [1:0] src;
        logic [2:0] div;
        logic       err;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{addr: 2'd0, data: 8'h31, src: 2'd1, div: 3'd3, err: 1'b0},
        '{addr: 2'd0, data: 8'h00, src: 2'd0, div: 3'd0, err: 1'b0},
        '{addr: 2'd0, data: 8'h72, src: 2'd0, div: 3'd0, err: 1'b1},
        '{addr: 2'd3, data: 8'h02, src: 2'd0, div: 3'd0, err: 1'b0},
        '{addr: 2'd0, data: 8'h53, src: 2'd0, div: 3'd0, err: 1'b1},
        '{addr: 2'd3, data: 8'h02, src: 2'd0, div: 3'd0, err: 1'b0},
        '{addr: 2'd0, data: 8'h61, src: 2'd1, div: 3'd6, err: 1'b0},
        '{addr: 2'd0, data: 8'h10, src: 2'd0, div: 3'd1, err: 1'b0}
    };

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_wait();
        wait_req = 1'b1;
        @(negedge clk);
        wait_req = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", "src", 8'(src_sel), 8'd0);
        check("R1", "div", 8'(div_code), 8'd4);
        check("R1", "pll_en", 8'(pll_en), 8'd0);
        check("R1", "mult", 8'(pll_mult), 8'd0);
        check("R1", "flags", 8'({pll_ready, irq, failover_flag, err_flag, wait_go, stop_go}), 8'd0);

        // R4 and R3 through the vector table
        for (int i = 0; i < NV; i++) begin
            do_write(VECS[i].addr, VECS[i].data);
            check("R4", "table src", 8'(src_sel), 8'(VECS[i].src));
            check("R4", "table div", 8'(div_code), 8'(VECS[i].div));
            check("R3", "table err", 8'(err_flag), 8'(VECS[i].err));
        end

        // R5 write-once multiplier
        do_write(2'd1, 8'h01);
        check("R5", "first mult", 8'(pll_mult), 8'd1);
        do_write(2'd1, 8'h02);
        check("R5", "second mult ignored", 8'(pll_mult), 8'd1);

        // R2 settling
        do_write(2'd1, 8'h82);
        check("R10", "pll_en set", 8'(pll_en), 8'd1);
        check("R5", "mult after enable", 8'(pll_mult), 8'd1);
        repeat (SETTLE - 1) @(negedge clk);
        check("R2", "not ready one early", 8'(pll_ready), 8'd0);
        @(negedge clk);
        check("R2", "ready at boundary", 8'(pll_ready), 8'd1);

        // R3 accepted PLL select once ready
        do_write(2'd0, 8'h42);
        check("R3", "pll selected", 8'(src_sel), 8'd2);
        check("R3", "no error", 8'(err_flag), 8'd0);

        // R10 disable refused while PLL selected
        do_write(2'd1, 8'h00);
        check("R10", "pll kept on", 8'(pll_en), 8'd1);
        check("R10", "err set", 8'(err_flag), 8'd1);
        do_write(2'd3, 8'h02);
        check("R7", "err cleared", 8'(err_flag), 8'd0);

        // R8 wait refused on PLL
        pulse_wait();
        check("R8", "wait refused", 8'(wait_go), 8'd0);
        check("R8", "wait err", 8'(err_flag), 8'd1);
        do_write(2'd3, 8'h02);

        // R9 stop refused with PLL enabled though main selected
        do_write(2'd0, 8'h41);
        check("R4", "back to main", 8'(src_sel), 8'd1);
        pulse_stop();
        check("R9", "stop refused", 8'(stop_go), 8'd0);
        check("R9", "stop err", 8'(err_flag), 8'd1);
        do_write(2'd3, 8'h02);
        do_write(2'd1, 8'h00);
        check("R2", "ready drops", 8'(pll_ready), 8'd0);
        pulse_stop();
        check("R9", "stop granted", 8'(stop_go), 8'd1);
        check("R9", "no err", 8'(err_flag), 8'd0);
        @(negedge clk);
        check("R9", "stop one cycle", 8'(stop_go), 8'd0);
        pulse_wait();
        check("R8", "wait granted", 8'(wait_go), 8'd1);

        // R2 restart: new enable counts from zero
        do_write(2'd1, 8'h80);
        repeat (SETTLE - 1) @(negedge clk);
        check("R2", "restart not early", 8'(pll_ready), 8'd0);
        @(negedge clk);
        check("R2", "restart ready", 8'(pll_ready), 8'd1);
        do_write(2'd1, 8'h00);

        // R6 half armed: no effect
        do_write(2'd2, 8'h01);
        main_stopped = 1'b1;
        @(negedge clk);
        check("R6", "half armed src", 8'(src_sel), 8'd1);
        check("R6", "half armed irq", 8'(irq), 8'd0);
        check("R6", "half armed flag", 8'(failover_flag), 8'd0);
        main_stopped = 1'b0;
        @(negedge clk);

        // R6 fully armed failover
        do_write(2'd2, 8'h03);
        main_stopped = 1'b1;
        @(negedge clk);
        check("R6", "failover src", 8'(src_sel), 8'd0);
        check("R6", "irq pulse", 8'(irq), 8'd1);
        check("R6", "flag set", 8'(failover_flag), 8'd1);
        @(negedge clk);
        check("R6", "irq one cycle", 8'(irq), 8'd0);
        main_stopped = 1'b0;

        // R7 clear failover flag
        do_write(2'd3, 8'h01);
        check("R7", "flag cleared", 8'(failover_flag), 8'd0);

        finish_run();
    end
endmodule